// File: doc/BRIEF.md
# Transparent receive descriptor ring engine

This block takes characters from a serial channel that applies no framing, holds them in a small internal FIFO, and stores them in memory buffers. Software describes each buffer with a descriptor that has three parts: a status word, a length word and a 32-bit buffer pointer. The descriptors form a ring. A status bit tells whether the engine or software currently owns a descriptor. A second status bit marks the last descriptor in the ring.

The engine reads a descriptor and checks that it owns it, then writes incoming characters into that buffer one byte at a time. It closes the buffer for one of three reasons: the buffer is full, the FIFO overran, or a hunt command arrived. To close a buffer, the engine writes back the length and the status word and pulses an interrupt that can be masked. It then moves to the next descriptor, or back to the ring base after the marked last descriptor. If the next descriptor is still owned by software, the engine drops incoming characters and raises a busy flag until software hands that descriptor back.

The memory port is a simple synchronous one. A read returns its data in the cycle after the request. A write is byte-masked and takes effect at the clock edge.

Top module: `rxring_engine`

## Requirements
- R1: While `rst` is high and in the cycles after it is released, `rx_irq` and `busy` are 0. No memory write is issued before a character has arrived.
- R2: Each descriptor spans 8 bytes in 16-bit words. The status word is at +0, the length at +2, the upper pointer half at +4 and the lower pointer half at +6. The n-th character stored in a buffer goes to byte address pointer+n. An even address uses `mem_be`=10 with the data on bits 15:8. An odd address uses `mem_be`=01 with the data on bits 7:0.
- R3: A close writes the stored byte count to +2 first. In the next cycle it writes the status word to +0. In that status word the owner bit 15 is 0, the last-in-ring bit 13 keeps its fetched value, the overrun bit 1 is set as required, and every other bit is 0.
- R4: A buffer closes when its stored count reaches `max_len`. Each close gives exactly one single-cycle `rx_irq` pulse when `int_en` is 1, and no pulse when `int_en` is 0.
- R5: After a close, the next descriptor is the current one plus 8. If the closed descriptor had bit 13 set, the next descriptor is `ring_base` instead.
- R6: When the fetched status has bit 15 equal to 0, the engine discards arriving characters and sets `busy` to 1. It polls that status word until bit 15 reads 1, and then clears `busy`. While `busy` is 1, no memory write is issued.
- R7: A character that arrives while the 4-entry FIFO is full, in a cycle when no entry leaves, replaces the newest entry. The character it replaces is lost. The replacing character is stored and the buffer then closes with status bit 1 set. Reception continues in the next descriptor. A close takes two cycles and a descriptor fetch takes four, and the FIFO is not read during those cycles.
- R8: A `hunt` pulse while the buffer holds at least one byte closes that buffer with its count. The engine then discards characters until a `restart` pulse, and after it continues with the next descriptor.
- R9: A `hunt` pulse while the buffer holds no bytes does not close it. After `restart`, characters are stored from the start of the same buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | 32 | Byte address of the first descriptor |
| max_len | input | 16 | Byte count at which a buffer is full |
| int_en | input | 1 | Enables the close interrupt |
| hunt | input | 1 | Hunt command pulse |
| restart | input | 1 | Ends hunt mode |
| rx_valid | input | 1 | A character is present this cycle |
| rx_data | input | 8 | Received character |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_be | output | 2 | Byte lanes written (bit 1 = bits 15:8) |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| rx_irq | output | 1 | One-cycle buffer close interrupt |
| busy | output | 1 | Next descriptor not available, characters discarded |

## Verification
The hardest state to reach from the ports is a FIFO overrun. While the engine is filling a buffer it drains one character per cycle, so an overrun can happen only while the FIFO is not being read. The stimulus therefore sends a continuous burst of characters that runs across a full-buffer close and the fetch of the next descriptor. Those six cycles with no reads fill the FIFO and then overwrite its newest entry several times. The burst stops before the engine starts reading the FIFO again. The second buffer must therefore hold the three oldest waiting characters plus the final character of the burst, and it must close with the overrun bit set.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned ADDR_W     = 2 * WORD_W;
  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned OFS_LEN    = 2;
  localparam int unsigned OFS_PHI    = 4;
  localparam int unsigned OFS_PLO    = 6;
  localparam int unsigned ST_OWN     = 15;
  localparam int unsigned ST_LAST    = 13;
  localparam int unsigned ST_OVR     = 1;

  typedef enum logic [2:0] {
    S_RD_ST, S_RD_PH, S_RD_PL, S_RD_LAST,
    S_FILL, S_CL_LEN, S_CL_STAT, S_HUNT
  } eng_state_t;
endpackage

// File: rtl/rxr_fifo.sv
module rxr_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          empty,
  output logic [DW-1:0] head_data,
  output logic          head_ov
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW:0]   store [DEPTH];
  logic [PW-1:0] rd_q, wr_q, wr_addr;
  logic [CW-1:0] cnt_q;
  logic          full, do_pop, do_push, ovr;

  function automatic logic [PW-1:0] step_up(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] step_dn(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign ovr     = push && full && !do_pop;
  assign wr_addr = ovr ? step_dn(wr_q) : wr_q;
  assign {head_ov, head_data} = store[rd_q];

  // single write port: a normal push or an overwrite of the newest entry
  always_ff @(posedge clk) begin
    if (do_push || ovr) store[wr_addr] <= {ovr, push_data};
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= step_up(wr_q);
      if (do_pop)  rd_q <= step_up(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
  import rxr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [WORD_W-1:0] max_len,
  input  logic              int_en,
  input  logic              hunt,
  input  logic              restart,
  input  logic              fifo_empty,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              fifo_ov,
  output logic              fifo_pop,
  output logic              fifo_flush,
  output logic              mem_en,
  output logic              mem_we,
  output logic [1:0]        mem_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              rx_irq,
  output logic              busy
);
  eng_state_t        state_q;
  logic [ADDR_W-1:0] desc_q, ptr_q, byte_addr;
  logic [WORD_W-1:0] ptr_hi_q, count_q, stat_word;
  logic              last_q, ovf_q, hunt_pend_q, hunt_after_q;
  logic              busy_q, irq_q, at_limit;

  assign byte_addr = ptr_q + ADDR_W'(count_q);
  assign at_limit  = ({1'b0, count_q} + 17'd1) >= {1'b0, max_len};
  assign rx_irq    = irq_q;
  assign busy      = busy_q;

  always_comb begin
    stat_word          = '0;
    stat_word[ST_LAST] = last_q;
    stat_word[ST_OVR]  = ovf_q;
    mem_en     = 1'b0;
    mem_we     = 1'b0;
    mem_be     = 2'b00;
    mem_addr   = '0;
    mem_wdata  = '0;
    fifo_pop   = 1'b0;
    fifo_flush = 1'b0;
    case (state_q)
      S_RD_ST: begin
        mem_en   = 1'b1;
        mem_addr = desc_q;
        fifo_pop = busy_q;
      end
      S_RD_PH: begin
        fifo_pop = busy_q;
        if (mem_rdata[ST_OWN]) begin
          mem_en   = 1'b1;
          mem_addr = desc_q + ADDR_W'(OFS_PHI);
        end
      end
      S_RD_PL: begin
        mem_en   = 1'b1;
        mem_addr = desc_q + ADDR_W'(OFS_PLO);
      end
      S_FILL: begin
        if (!hunt_pend_q && !fifo_empty) begin
          fifo_pop  = 1'b1;
          mem_en    = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = byte_addr;
          mem_be    = byte_addr[0] ? 2'b01 : 2'b10;
          mem_wdata = {fifo_data, fifo_data};
        end
      end
      S_CL_LEN: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 2'b11;
        mem_addr  = desc_q + ADDR_W'(OFS_LEN);
        mem_wdata = count_q;
      end
      S_CL_STAT: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 2'b11;
        mem_addr  = desc_q;
        mem_wdata = stat_word;
      end
      S_HUNT:  fifo_flush = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_RD_ST;
      desc_q       <= ring_base;
      ptr_q        <= '0;
      ptr_hi_q     <= '0;
      count_q      <= '0;
      last_q       <= 1'b0;
      ovf_q        <= 1'b0;
      hunt_pend_q  <= 1'b0;
      hunt_after_q <= 1'b0;
      busy_q       <= 1'b0;
      irq_q        <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (hunt && state_q != S_HUNT) hunt_pend_q <= 1'b1;
      case (state_q)
        S_RD_ST: state_q <= S_RD_PH;
        S_RD_PH: begin
          last_q <= mem_rdata[ST_LAST];
          if (mem_rdata[ST_OWN]) begin
            busy_q  <= 1'b0;
            state_q <= S_RD_PL;
          end else begin
            busy_q  <= 1'b1;
            state_q <= S_RD_ST;
          end
        end
        S_RD_PL: begin
          ptr_hi_q <= mem_rdata;
          state_q  <= S_RD_LAST;
        end
        S_RD_LAST: begin
          ptr_q   <= {ptr_hi_q, mem_rdata};
          count_q <= '0;
          ovf_q   <= 1'b0;
          state_q <= S_FILL;
        end
        S_FILL: begin
          if (hunt_pend_q) begin
            hunt_pend_q <= 1'b0;
            if (count_q != '0) begin
              hunt_after_q <= 1'b1;
              state_q      <= S_CL_LEN;
            end else begin
              state_q <= S_HUNT;
            end
          end else if (!fifo_empty) begin
            count_q <= count_q + 1'b1;
            if (fifo_ov) ovf_q <= 1'b1;
            if (fifo_ov || at_limit) state_q <= S_CL_LEN;
          end
        end
        S_CL_LEN: state_q <= S_CL_STAT;
        S_CL_STAT: begin
          irq_q  <= int_en;
          desc_q <= last_q ? ring_base : desc_q + ADDR_W'(DESC_BYTES);
          if (hunt_after_q) begin
            hunt_after_q <= 1'b0;
            state_q      <= S_HUNT;
          end else begin
            state_q <= S_RD_ST;
          end
        end
        S_HUNT: if (restart) state_q <= S_RD_ST;
        default: state_q <= S_RD_ST;
      endcase
    end
  end
endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
  import rxr_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [WORD_W-1:0] max_len,
  input  logic              int_en,
  input  logic              hunt,
  input  logic              restart,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [1:0]        mem_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              rx_irq,
  output logic              busy
);
  logic              f_empty, f_ov, f_pop, f_flush;
  logic [BYTE_W-1:0] f_data;

  rxr_fifo #(.DEPTH(FIFO_DEPTH), .DW(BYTE_W)) u_fifo (
    .clk(clk), .rst(rst), .flush(f_flush),
    .push(rx_valid), .push_data(rx_data), .pop(f_pop),
    .empty(f_empty), .head_data(f_data), .head_ov(f_ov)
  );

  rxr_engine u_eng (
    .clk(clk), .rst(rst), .ring_base(ring_base), .max_len(max_len),
    .int_en(int_en), .hunt(hunt), .restart(restart),
    .fifo_empty(f_empty), .fifo_data(f_data), .fifo_ov(f_ov),
    .fifo_pop(f_pop), .fifo_flush(f_flush),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rx_irq(rx_irq), .busy(busy)
  );
endmodule

// File: rtl/rxring_engine_chk.sv
module rxring_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        int_en,
  input logic        mem_en,
  input logic        mem_we,
  input logic [1:0]  mem_be,
  input logic [31:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        rx_irq,
  input logic        busy
);
  logic stat_wr, len_wr, byte_wr;
  assign stat_wr = mem_en && mem_we && (mem_be == 2'b11) && (mem_addr[2:0] == 3'd0);
  assign len_wr  = mem_en && mem_we && (mem_be == 2'b11) && (mem_addr[2:0] == 3'd2);
  assign byte_wr = mem_en && mem_we && (mem_be != 2'b11);

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (rst) rx_irq |=> !rx_irq);
  // R4
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst) rx_irq |-> $past(int_en));
  // R4
  irq_after_close_chk: assert property (@(posedge clk) disable iff (rst) rx_irq |-> $past(stat_wr));
  // R3
  status_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    stat_wr |-> ((mem_wdata & 16'hDFFD) == 16'h0000));
  // R3
  len_first_chk: assert property (@(posedge clk) disable iff (rst) stat_wr |-> $past(len_wr));
  // R2
  byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
    byte_wr |-> (mem_be == (mem_addr[0] ? 2'b01 : 2'b10)));
  // R6
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst) busy |-> !mem_we);
endmodule

bind rxring_engine rxring_engine_chk u_chk (.*);

// File: tb/rxring_engine_tb.sv
`timescale 1ns/1ps
module rxring_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ring_base = 32'h0;
  logic [15:0] max_len = 16'd4;
  logic        int_en = 1'b1;
  logic        hunt = 1'b0;
  logic        restart = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h0;
  logic        mem_en, mem_we, rx_irq, busy;
  logic [1:0]  mem_be;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'h0;

  logic [15:0] mem [0:511];
  logic [39:0] byte_q [$];
  logic [63:0] close_q [$];
  logic [15:0] last_len = 16'h0;
  int checks = 0, errors = 0, irq_cnt = 0;

  always #2 clk = ~clk;

  rxring_engine u_dut (
    .clk(clk), .rst(rst), .ring_base(ring_base), .max_len(max_len),
    .int_en(int_en), .hunt(hunt), .restart(restart),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_irq(rx_irq), .busy(busy)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        if (mem_be[1]) mem[mem_addr[9:1]][15:8] <= mem_wdata[15:8];
        if (mem_be[0]) mem[mem_addr[9:1]][7:0]  <= mem_wdata[7:0];
      end else begin
        mem_rdata <= mem[mem_addr[9:1]];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_irq) irq_cnt++;
      if (mem_en && mem_we) begin
        if (mem_be == 2'b11) begin
          if (mem_addr[2:0] == 3'd2) last_len = mem_wdata;
          else begin
            logic [63:0] got, e;
            got = {mem_addr, mem_wdata, last_len};
            e = (close_q.size() != 0) ? close_q.pop_front() : 64'hX;
            check(got === e, "R3 R5 R7 close record", got, e);
          end
        end else begin
          logic [39:0] gb, eb;
          gb = {mem_addr, (mem_addr[0] ? mem_wdata[7:0] : mem_wdata[15:8])};
          eb = (byte_q.size() != 0) ? byte_q.pop_front() : 40'hX;
          check(gb === eb, "R2 byte store", {24'h0, gb}, {24'h0, eb});
        end
      end
    end
  end

  task automatic exp_byte(input logic [31:0] a, input logic [7:0] d);
    byte_q.push_back({a, d});
  endtask

  task automatic exp_close(input logic [31:0] a, input logic [15:0] st, input logic [15:0] len);
    close_q.push_back({a, st, len});
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
    wait_cyc(2);
  endtask

  task automatic pulse_hunt();
    @(negedge clk); hunt = 1'b1;
    @(negedge clk); hunt = 1'b0;
  endtask

  task automatic pulse_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 64'h0, 64'h1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 16'h0;
    mem[0] = 16'h8400; mem[3]  = 16'h0100;   // reserved bit must come back 0
    mem[4] = 16'h8000; mem[7]  = 16'h0120;
    mem[8] = 16'hA000; mem[11] = 16'h0140;   // last in ring
    wait_cyc(5);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(busy == 1'b0 && rx_irq == 1'b0, "R1 reset outputs", {busy, rx_irq}, 0);
    wait_cyc(8);
    check(busy == 1'b0, "R1 idle busy", busy, 0);

    // R4 full close with interrupt, R2 byte lanes
    for (int i = 0; i < 4; i++) exp_byte(32'h100 + i, 8'h11 * (i + 1));
    exp_close(32'h0, 16'h0000, 16'd4);
    for (int i = 0; i < 4; i++) send(8'h11 * (i + 1));
    wait_cyc(10);
    check(irq_cnt == 1, "R4 irq on full close", irq_cnt, 1);

    // R4 masked interrupt
    int_en = 1'b0;
    for (int i = 0; i < 4; i++) exp_byte(32'h120 + i, 8'h50 + i);
    exp_close(32'h8, 16'h0000, 16'd4);
    for (int i = 0; i < 4; i++) send(8'h50 + i);
    wait_cyc(10);
    check(irq_cnt == 1, "R4 masked irq", irq_cnt, 1);
    int_en = 1'b1;

    // R5 last-in-ring descriptor, R6 busy on software-owned descriptor
    for (int i = 0; i < 4; i++) exp_byte(32'h140 + i, 8'h60 + i);
    exp_close(32'h10, 16'h2000, 16'd4);
    for (int i = 0; i < 4; i++) send(8'h60 + i);
    wait_cyc(10);
    check(irq_cnt == 2, "R4 irq count", irq_cnt, 2);
    check(busy == 1'b1, "R6 busy after wrap to owned-by-software", busy, 1);
    send(8'hEE); send(8'hEF);
    check(busy == 1'b1, "R6 busy holds, chars dropped", busy, 1);
    mem[0] = 16'h8000; mem[4] = 16'h8000; mem[8] = 16'hA000;
    wait_cyc(10);
    check(busy == 1'b0, "R6 busy clears", busy, 0);

    // R8 hunt with data closes the buffer; R5 data went to ring base buffer
    max_len = 16'd6;
    exp_byte(32'h100, 8'h71); exp_byte(32'h101, 8'h72);
    exp_close(32'h0, 16'h0000, 16'd2);
    send(8'h71); send(8'h72);
    wait_cyc(3);
    pulse_hunt();
    wait_cyc(10);
    check(irq_cnt == 3, "R8 hunt close irq", irq_cnt, 3);
    send(8'hD1); send(8'hD2);
    pulse_restart();
    wait_cyc(10);

    // R9 hunt with empty buffer: no close
    pulse_hunt();
    wait_cyc(5);
    send(8'hD3);
    pulse_restart();
    wait_cyc(10);
    check(irq_cnt == 3, "R9 no close on empty hunt", irq_cnt, 3);

    // R7 overrun burst across a close and fetch; R9 same buffer reused
    for (int i = 0; i < 6; i++) exp_byte(32'h120 + i, 8'hA0 + i);
    exp_close(32'h8, 16'h0000, 16'd6);
    exp_byte(32'h140, 8'hA6); exp_byte(32'h141, 8'hA7);
    exp_byte(32'h142, 8'hA8); exp_byte(32'h143, 8'hAC);
    exp_close(32'h10, 16'h2002, 16'd4);
    for (int i = 0; i < 13; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'hA0 + i;
    end
    @(negedge clk); rx_valid = 1'b0;
    wait_cyc(30);
    check(irq_cnt == 5, "R7 irq after overrun close", irq_cnt, 5);
    check(busy == 1'b1, "R5 wrap back to base owned by software", busy, 1);
    check(byte_q.size() == 0, "R2 R7 all bytes stored", byte_q.size(), 0);
    check(close_q.size() == 0, "R3 all closes seen", close_q.size(), 0);
    finish_run();
  end
endmodule